// File: doc/BRIEF.md
# Store Set Identifier Table

This block maps the address of a load or store instruction to an optional store-set number. An out-of-order core's dependence predictor uses it. At fetch, an instruction presents its PC on the lookup port. In the same cycle the port returns a hit flag and, on a hit, the 7-bit set number held in the entry that the PC selects. The table stores no tag, so unrelated instructions whose index bits match share one entry.

When the core detects a memory-order violation, it presents the offending load PC and store PC on the violation port for one cycle. The table then creates a set, extends an existing one, or merges two sets. Merging keeps the numerically smaller set number. A free-running interval counter periodically starts a sweep that walks the entries in ascending order, one per cycle, and drops their valid bits. This lets stale dependences age out. Recovery from any kind of misspeculation does not touch the table, and no port exists for it.

Top module: `ssid_table`

## Requirements
- R1: The entry is selected by PC bits [IDX_W+1:2] with no tag compare, so two PCs that agree in those bits read and write the same entry.
- R2: While reset is asserted and after it is released, every entry is invalid and a lookup returns lk_hit=0 and lk_ssid=0.
- R3: Lookup is combinational on the stored contents: an update made at a clock edge is visible on lk_hit/lk_ssid right after that edge.
- R4: On a violation where neither the load entry nor the store entry is valid, both become valid with a new number equal to PC[8:2] XOR PC[15:9] of the load PC.
- R5: On a violation where only the load entry is valid, the store entry becomes valid with the load entry's number.
- R6: On a violation where only the store entry is valid, the load entry becomes valid with the store entry's number.
- R7: On a violation where both entries are valid with different numbers, only the entry holding the larger number is rewritten, with the smaller number. No other entry changes.
- R8: On a violation where both entries are valid with equal numbers, nothing changes.
- R9: Every INTERVAL cycles a sweep starts. In the k-th cycle after the start (k from 1), it invalidates entry k-1, so entries are cleared in ascending order, one per cycle.
- R10: If a violation writes the entry that the sweep clears in the same cycle, the written entry ends valid with the written number.
- R11: Reset restarts the interval count and the sweep position, so the first sweep after reset clears entry 0 at the (INTERVAL+1)-th clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| lk_pc | input | PC_W | PC presented for fetch-time lookup |
| lk_hit | output | 1 | Selected entry holds a valid set number |
| lk_ssid | output | SSID_W | Set number of the selected entry, zero when not valid |
| viol_valid | input | 1 | A violation pair is presented this cycle |
| viol_load_pc | input | PC_W | PC of the load in the violation |
| viol_store_pc | input | PC_W | PC of the store in the violation |

## Verification
A violation update and the sweep's clear can land on the same entry in the same cycle. The bench counts clock edges from reset release, computes which edge the sweep reaches a chosen entry, and presents a violation for that entry in exactly that cycle. The entry must survive with the written number while its neighbours on either side of the sweep position show the expected cleared or still-valid state. A second reset followed by a write to entry 0 shows that both the interval count and the sweep position restart.

// File: rtl/ssid_pkg.sv
package ssid_pkg;

  // Which of the update cases a violation pair falls into
  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_ALLOC,
    UPD_COPY_TO_ST,
    UPD_COPY_TO_LD,
    UPD_MERGE_INTO_ST,
    UPD_MERGE_INTO_LD
  } upd_kind_e;

endpackage

// File: rtl/ssid_pc_map.sv
module ssid_pc_map #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int SSID_W = 7,
  parameter int HASH_W = 14
) (
  input  logic [PC_W-1:0]   pc,
  output logic [IDX_W-1:0]  idx,
  output logic [SSID_W-1:0] hash
);
  localparam int NCHUNK = (HASH_W + SSID_W - 1) / SSID_W;
  localparam int PADW   = NCHUNK * SSID_W;

  logic [PADW-1:0] src;

  assign idx = pc[IDX_W+1:2];

  always_comb begin
    src = '0;
    src[HASH_W-1:0] = pc[HASH_W+1:2];
  end

  always_comb begin
    hash = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      hash = hash ^ src[c*SSID_W +: SSID_W];
    end
  end
endmodule

// File: rtl/ssid_merge_rule.sv
module ssid_merge_rule
  import ssid_pkg::*;
#(
  parameter int SSID_W = 7
) (
  input  logic              viol,
  input  logic              ld_vld,
  input  logic [SSID_W-1:0] ld_id,
  input  logic              st_vld,
  input  logic [SSID_W-1:0] st_id,
  input  logic [SSID_W-1:0] new_id,
  output logic              wr_ld,
  output logic              wr_st,
  output logic [SSID_W-1:0] wr_id
);
  upd_kind_e kind;

  always_comb begin
    kind = UPD_NONE;
    if (viol) begin
      unique case ({ld_vld, st_vld})
        2'b00:   kind = UPD_ALLOC;
        2'b10:   kind = UPD_COPY_TO_ST;
        2'b01:   kind = UPD_COPY_TO_LD;
        default: begin
          if (ld_id < st_id)      kind = UPD_MERGE_INTO_ST;
          else if (st_id < ld_id) kind = UPD_MERGE_INTO_LD;
          else                    kind = UPD_NONE;
        end
      endcase
    end
  end

  always_comb begin
    wr_ld = 1'b0;
    wr_st = 1'b0;
    wr_id = '0;
    unique case (kind)
      UPD_ALLOC:         begin wr_ld = 1'b1; wr_st = 1'b1; wr_id = new_id; end
      UPD_COPY_TO_ST:    begin wr_st = 1'b1; wr_id = ld_id; end
      UPD_COPY_TO_LD:    begin wr_ld = 1'b1; wr_id = st_id; end
      UPD_MERGE_INTO_ST: begin wr_st = 1'b1; wr_id = ld_id; end
      UPD_MERGE_INTO_LD: begin wr_ld = 1'b1; wr_id = st_id; end
      default:           ;
    endcase
  end
endmodule

// File: rtl/ssid_sweeper.sv
module ssid_sweeper #(
  parameter int IDX_W    = 12,
  parameter int INTERVAL = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);
  localparam logic [IDX_W-1:0] PTR_LAST = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             tick;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    act_d = act_q;
    ptr_d = ptr_q;
    if (tick) begin
      act_d = 1'b1;
      ptr_d = '0;
    end else if (act_q) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PTR_LAST) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      ptr_q <= ptr_d;
    end
  end

  assign clr_en  = act_q;
  assign clr_idx = ptr_q;

  // R9
  sweep_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ptr_q == PTR_LAST && !tick) |=> !act_q);

  // R9
  sweep_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ptr_q != PTR_LAST && !tick) |=> (act_q && ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/ssid_table.sv
module ssid_table #(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 12,
  parameter int SSID_W   = 7,
  parameter int HASH_W   = 14,
  parameter int INTERVAL = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  output logic [SSID_W-1:0] lk_ssid,
  input  logic              viol_valid,
  input  logic [PC_W-1:0]   viol_load_pc,
  input  logic [PC_W-1:0]   viol_store_pc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NMAP  = 3;

  logic [NMAP-1:0][PC_W-1:0]   map_pc;
  logic [NMAP-1:0][IDX_W-1:0]  map_idx;
  logic [NMAP-1:0][SSID_W-1:0] map_hash;

  assign map_pc[0] = lk_pc;
  assign map_pc[1] = viol_load_pc;
  assign map_pc[2] = viol_store_pc;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    ssid_pc_map #(.PC_W(PC_W), .IDX_W(IDX_W), .SSID_W(SSID_W), .HASH_W(HASH_W)) u_map (
      .pc  (map_pc[g]),
      .idx (map_idx[g]),
      .hash(map_hash[g])
    );
  end

  logic [IDX_W-1:0]  lk_idx, ld_idx, st_idx;
  logic [SSID_W-1:0] ld_hash;
  assign lk_idx  = map_idx[0];
  assign ld_idx  = map_idx[1];
  assign st_idx  = map_idx[2];
  assign ld_hash = map_hash[1];

  // Storage: valid bits carry reset, numbers do not
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [SSID_W-1:0] id_q [DEPTH];

  logic              ld_vld, st_vld;
  logic [SSID_W-1:0] ld_id, st_id;
  assign ld_vld = vld_q[ld_idx];
  assign st_vld = vld_q[st_idx];
  assign ld_id  = id_q[ld_idx];
  assign st_id  = id_q[st_idx];

  logic              wr_ld, wr_st;
  logic [SSID_W-1:0] wr_id;

  ssid_merge_rule #(.SSID_W(SSID_W)) u_rule (
    .viol  (viol_valid),
    .ld_vld(ld_vld),
    .ld_id (ld_id),
    .st_vld(st_vld),
    .st_id (st_id),
    .new_id(ld_hash),
    .wr_ld (wr_ld),
    .wr_st (wr_st),
    .wr_id (wr_id)
  );

  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;

  ssid_sweeper #(.IDX_W(IDX_W), .INTERVAL(INTERVAL)) u_sweep (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (clr_en),
    .clr_idx(clr_idx)
  );

  // Clear first, writes after: a violation write wins on the same entry
  always_comb begin
    vld_d = vld_q;
    if (clr_en) vld_d[clr_idx] = 1'b0;
    if (wr_ld)  vld_d[ld_idx]  = 1'b1;
    if (wr_st)  vld_d[st_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ld) id_q[ld_idx] <= wr_id;
    if (wr_st) id_q[st_idx] <= wr_id;
  end

  assign lk_hit  = vld_q[lk_idx];
  assign lk_ssid = lk_hit ? id_q[lk_idx] : '0;

  // R4
  alloc_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !ld_vld && !st_vld) |=>
      (vld_q[$past(ld_idx)] && vld_q[$past(st_idx)] &&
       id_q[$past(ld_idx)] == $past(ld_hash) && id_q[$past(st_idx)] == $past(ld_hash)));

  // R5
  copy_to_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && ld_vld && !st_vld) |=>
      (vld_q[$past(st_idx)] && id_q[$past(st_idx)] == $past(ld_id)));

  // R6
  copy_to_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !ld_vld && st_vld) |=>
      (vld_q[$past(ld_idx)] && id_q[$past(ld_idx)] == $past(st_id)));

  // R7
  merge_smaller_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && ld_vld && st_vld && ld_id != st_id) |=>
      (id_q[$past(ld_idx)] == id_q[$past(st_idx)] &&
       id_q[$past(ld_idx)] == (($past(ld_id) < $past(st_id)) ? $past(ld_id) : $past(st_id))));

  // R9
  sweep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(viol_valid && (clr_idx == ld_idx || clr_idx == st_idx))) |=>
      !vld_q[$past(clr_idx)]);

  // R10
  write_beats_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ((wr_ld && clr_idx == ld_idx) || (wr_st && clr_idx == st_idx))) |=>
      vld_q[$past(clr_idx)]);
endmodule

// File: tb/sim_ssid_table.sv
`timescale 1ns/1ps
module sim_ssid_table;
  localparam int PC_W     = 32;
  localparam int IDX_W    = 4;
  localparam int SSID_W   = 7;
  localparam int HASH_W   = 14;
  localparam int INTERVAL = 200;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int NVEC     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PC_W-1:0]   lk_pc;
  logic              lk_hit;
  logic [SSID_W-1:0] lk_ssid;
  logic              viol_valid;
  logic [PC_W-1:0]   viol_load_pc, viol_store_pc;

  int checks = 0;
  int failures = 0;
  int ecount;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssid_table #(.PC_W(PC_W), .IDX_W(IDX_W), .SSID_W(SSID_W), .HASH_W(HASH_W),
               .INTERVAL(INTERVAL)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_ssid(lk_ssid),
    .viol_valid(viol_valid), .viol_load_pc(viol_load_pc), .viol_store_pc(viol_store_pc)
  );

  // Clock edges seen since reset release
  always_ff @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  // {load pc, store pc, expected number at load pc, expected number at store pc}
  localparam logic [2*PC_W+2*SSID_W-1:0] VEC [NVEC] = '{
    {32'h0000_0010, 32'h0000_0024, 7'd4,  7'd4},   // R4 fresh pair, hash 4
    {32'h0000_0030, 32'h0000_0024, 7'd4,  7'd4},   // R6 store side valid
    {32'h0000_0030, 32'h0000_0028, 7'd4,  7'd4},   // R5 load side valid, copied number not its hash
    {32'h0000_1014, 32'h0000_0018, 7'd13, 7'd13},  // R4 hash folds upper half (5 xor 8)
    {32'h0000_1014, 32'h0000_0010, 7'd4,  7'd4},   // R7 store holds smaller
    {32'h0000_203C, 32'h0000_0038, 7'd31, 7'd31},  // R4 hash 15 xor 16
    {32'h0000_0018, 32'h0000_0038, 7'd13, 7'd13},  // R7 load holds smaller
    {32'h0000_0010, 32'h0000_0024, 7'd4,  7'd4}    // R8 equal numbers
  };

  task automatic check_lk(input logic [PC_W-1:0] pc, input logic exp_hit,
                          input logic [SSID_W-1:0] exp_id, input string req);
    lk_pc = pc;
    #0.5;
    checks++;
    if (lk_hit !== exp_hit || lk_ssid !== exp_id) begin
      failures++;
      $display("FAIL %s pc=%h actual hit=%0b id=%0d expected hit=%0b id=%0d",
               req, pc, lk_hit, lk_ssid, exp_hit, exp_id);
    end
  endtask

  task automatic pulse_viol(input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc);
    viol_load_pc  = lpc;
    viol_store_pc = spc;
    viol_valid    = 1'b1;
    @(negedge clk);
    viol_valid    = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (ecount < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    viol_valid = 1'b0;
    viol_load_pc = '0;
    viol_store_pc = '0;
    lk_pc = '0;
    repeat (3) @(negedge clk);
    // R2 invalid during reset
    check_lk(32'h0000_0010, 1'b0, '0, "R2");
    check_lk(32'h0000_003C, 1'b0, '0, "R2");
    rst_n = 1'b1;
    check_lk(32'h0000_0024, 1'b0, '0, "R2");

    // Vector table: R3 each result read right after the updating edge
    for (int i = 0; i < NVEC; i++) begin
      pulse_viol(VEC[i][2*PC_W+2*SSID_W-1 -: PC_W], VEC[i][PC_W+2*SSID_W-1 -: PC_W]);
      check_lk(VEC[i][2*PC_W+2*SSID_W-1 -: PC_W], 1'b1, VEC[i][2*SSID_W-1 -: SSID_W], "R3/vector");
      check_lk(VEC[i][PC_W+2*SSID_W-1 -: PC_W], 1'b1, VEC[i][SSID_W-1:0], "R3/vector");
    end
    // R7 entry outside the merged pair untouched
    check_lk(32'h0000_003C, 1'b1, 7'd31, "R7");
    // R1 aliasing PC reads an existing entry
    check_lk(32'h0000_0050, 1'b1, 7'd4, "R1");
    pulse_viol(32'h0000_0004, 32'h0000_0044);
    check_lk(32'h0000_0044, 1'b1, 7'd1, "R1");
    check_lk(32'hFFFF_0004, 1'b1, 7'd1, "R1");

    // R9 nothing cleared by the start edge itself
    wait_until(INTERVAL);
    check_lk(32'h0000_0010, 1'b1, 7'd4, "R9");
    // R10 violation on entry 3 in the cycle the sweep clears it
    wait_until(INTERVAL + 3);
    pulse_viol(32'h0000_000C, 32'h0000_000C);
    check_lk(32'h0000_000C, 1'b1, 7'd3, "R10");
    // R9 ascending order: entries 0..4 gone, entry 9 still there
    wait_until(INTERVAL + 5);
    check_lk(32'h0000_0010, 1'b0, '0, "R9");
    check_lk(32'h0000_0024, 1'b1, 7'd4, "R9");
    wait_until(INTERVAL + 1 + DEPTH);
    check_lk(32'h0000_0024, 1'b0, '0, "R9");
    check_lk(32'h0000_003C, 1'b0, '0, "R9");
    check_lk(32'h0000_0004, 1'b0, '0, "R9");
    check_lk(32'h0000_000C, 1'b1, 7'd3, "R10");

    // R2 reset clears, R11 counters restart
    rst_n = 1'b0;
    @(negedge clk);
    check_lk(32'h0000_000C, 1'b0, '0, "R2");
    rst_n = 1'b1;
    pulse_viol(32'h0000_0000, 32'h0000_0000);
    check_lk(32'h0000_0000, 1'b1, 7'd0, "R11");
    wait_until(INTERVAL);
    check_lk(32'h0000_0000, 1'b1, 7'd0, "R11");
    wait_until(INTERVAL + 1);
    check_lk(32'h0000_0000, 1'b0, '0, "R11");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule